// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts each virtual address into its address segment and resolves what can be resolved without a translation table. It works in a 32-bit mode and a 64-bit mode. The mode is taken from a mode input that is sampled into a register, so a request always uses the mode seen on the clock edge before the request is accepted. For the directly mapped windows it returns the page-aligned physical address, the in-page offset and a cached/uncached flag one cycle after the request is accepted. For table-mapped segments it raises a request on a TLB lookup port and holds it until the port acknowledges with a hit or a miss.

A failed translation reports an exception cause (TLB miss on load or store, address error on load or store) and loads the faulting virtual address into a bad-address register. A probe request goes through the same decoding but only reports success or failure. It raises no cause and leaves the bad-address register untouched. One request is handled at a time. While a TLB lookup is pending, the ready output is low and new requests are ignored.

Top module: `vseg_xlate`

## Requirements
- R1: The addressing mode is set by `mode64_i` (0 = 32-bit, 1 = 64-bit) sampled on each clock edge; a request accepted on an edge is decoded with the value sampled on the previous edge.
- R2: In 32-bit mode, address bits 31:29 equal to 4 or 5 are unmapped: the physical page is bits 28:12 of the address (the window base removed), `pa_page` carries it with bits 11:0 zero, `pa_off` is bits 11:0; value 4 is cached and 5 uncached; `done` and `ok` are high in the cycle after acceptance.
- R3: In 32-bit mode, values 0 to 3 and 6 to 7 of bits 31:29 are TLB-mapped: `tlb_req_valid` rises in the cycle after acceptance, carrying the low 32 address bits sign-extended to 64, and stays high with a stable address until `tlb_ack` is sampled.
- R4: In 64-bit mode, bits 63:40 equal to 0x000000, 0x400000 or 0xC00000, or 0xFFFFFF with bits 39:29 equal to 0x7FE or 0x7FF, are TLB-mapped and present the full 64-bit address to the TLB port.
- R5: In 64-bit mode, region 0xFFFFFF with bits 39:29 equal to 0x7FC (cached) or 0x7FD (uncached) is unmapped with the physical page taken from address bits 28:12.
- R6: In 64-bit mode, bits 63:62 = 2'b10 with bits 58:40 all zero form the physical window: the physical page is address bits PA_W-1:12, and the access is uncached when bits 60:59 equal 2 and cached otherwise.
- R7: Any other 64-bit region, and any other sub-segment of region 0xFFFFFF, is an address error: `ok` low, `exc_valid` high, cause 4 for a load or 5 for a store, `badvaddr` set to the address.
- R8: A TLB miss (`tlb_ack` with `tlb_hit` low) yields `ok` low, `exc_valid` high, cause 2 for a load or 3 for a store, and `badvaddr` set to the requested address.
- R9: A probe request (`req_probe` high) that fails completes with `done` high and `ok` low, raises no `exc_valid`, and leaves `badvaddr` unchanged.
- R10: A TLB hit completes in the cycle after the acknowledge, with `pa_page` equal to `tlb_ppage` shifted up by 12, `cached` equal to `tlb_cached`, and `pa_off` equal to address bits 11:0.
- R11: After reset, `req_ready` is 1, `done`, `exc_valid` and `tlb_req_valid` are 0, `badvaddr` is 0, and the mode is 32-bit.
- R12: While a TLB lookup is pending, `req_ready` is low and a request presented then is ignored and does not change the outcome of the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64_i | input | 1 | Addressing mode select, registered (1 = 64-bit) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_vaddr | input | 64 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_probe | input | 1 | Lookup only; exceptions suppressed |
| tlb_req_valid | output | 1 | TLB lookup pending |
| tlb_vaddr | output | 64 | Address presented to the TLB |
| tlb_ack | input | 1 | TLB response present |
| tlb_hit | input | 1 | TLB found a valid entry |
| tlb_ppage | input | PA_W-12 | Physical page number from the TLB |
| tlb_cached | input | 1 | Cache attribute from the TLB |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Translation succeeded |
| pa_page | output | PA_W | Page-aligned physical address |
| pa_off | output | 12 | Offset within the page |
| cached | output | 1 | Access is cacheable |
| exc_valid | output | 1 | Exception raised with this completion |
| exc_cause | output | 5 | Cause code (2, 3, 4, 5) |
| badvaddr | output | 64 | Last faulting virtual address |

## Verification
Random addresses are drawn per region class: fully random words that mostly land in illegal 64-bit regions, each extended segment, each compatibility sub-segment including the illegal ones, and every physical-window step with all four cache-field values, in both modes. Running the same address in both modes shows that the registered mode, not the address, selects the decode. Mixing loads, stores and probes over TLB hits and misses separates the four cause codes and shows the probe case leaving the bad-address register alone. Requests driven during a pending lookup, with random acknowledge delay, show that they are ignored.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

    typedef enum logic [1:0] {
        SEG_DIRECT = 2'd0,
        SEG_MAPPED = 2'd1,
        SEG_BAD    = 2'd2
    } seg_kind_e;

    typedef struct packed {
        seg_kind_e kind;
        logic      cached;
    } seg_res_t;

    localparam logic [4:0] CAUSE_TLB_LD = 5'd2;
    localparam logic [4:0] CAUSE_TLB_ST = 5'd3;
    localparam logic [4:0] CAUSE_ADR_LD = 5'd4;
    localparam logic [4:0] CAUSE_ADR_ST = 5'd5;

    localparam logic [1:0] CCA_UNCACHED = 2'd2;

    localparam logic [23:0] REG_XUSER = 24'h000000;
    localparam logic [23:0] REG_XSUP  = 24'h400000;
    localparam logic [23:0] REG_XKERN = 24'hC00000;
    localparam logic [23:0] REG_COMPAT = 24'hFFFFFF;

    localparam logic [10:0] SUB_CACHED   = 11'h7FC;
    localparam logic [10:0] SUB_UNCACHED = 11'h7FD;
    localparam logic [10:0] SUB_MAP_A    = 11'h7FE;
    localparam logic [10:0] SUB_MAP_B    = 11'h7FF;

    function automatic logic [4:0] pick_cause(input logic tlb_fault, input logic is_store);
        if (tlb_fault) return is_store ? CAUSE_TLB_ST : CAUSE_TLB_LD;
        return is_store ? CAUSE_ADR_ST : CAUSE_ADR_LD;
    endfunction

    function automatic logic [63:0] sext32(input logic [31:0] a);
        return {{32{a[31]}}, a};
    endfunction

endpackage

// File: rtl/vseg_decode32.sv
module vseg_decode32
    import vseg_pkg::*;
#(
    parameter int PA_W      = 36,
    parameter int PAGE_BITS = 12
) (
    input  logic [31:PAGE_BITS]   vaddr,
    output seg_res_t              res,
    output logic [PA_W-1:PAGE_BITS] page
);
    localparam int WIN_TOP = 29;

    always_comb begin
        res.kind   = SEG_MAPPED;
        res.cached = 1'b0;
        page       = '0;
        page[WIN_TOP-1:PAGE_BITS] = vaddr[WIN_TOP-1:PAGE_BITS];
        unique case (vaddr[31:WIN_TOP])
            3'd4: begin
                res.kind   = SEG_DIRECT;
                res.cached = 1'b1;
            end
            3'd5: begin
                res.kind   = SEG_DIRECT;
                res.cached = 1'b0;
            end
            default: res.kind = SEG_MAPPED;
        endcase
    end
endmodule

// File: rtl/vseg_decode64.sv
module vseg_decode64
    import vseg_pkg::*;
#(
    parameter int PA_W      = 36,
    parameter int PAGE_BITS = 12,
    parameter int CCA_LSB   = 59
) (
    input  logic [63:PAGE_BITS]     vaddr,
    output seg_res_t                res,
    output logic [PA_W-1:PAGE_BITS] page
);
    localparam int WIN_TOP = 29;

    logic [23:0] region;
    logic [10:0] sub;
    logic        phys_win;

    assign region   = vaddr[63:40];
    assign sub      = vaddr[39:WIN_TOP];
    assign phys_win = (region[23:22] == 2'b10) && (region[18:0] == '0);

    always_comb begin
        res.kind   = SEG_BAD;
        res.cached = 1'b0;
        page       = '0;
        if (region == REG_XUSER || region == REG_XSUP || region == REG_XKERN) begin
            res.kind = SEG_MAPPED;
        end else if (region == REG_COMPAT) begin
            unique case (sub)
                SUB_CACHED: begin
                    res.kind   = SEG_DIRECT;
                    res.cached = 1'b1;
                    page[WIN_TOP-1:PAGE_BITS] = vaddr[WIN_TOP-1:PAGE_BITS];
                end
                SUB_UNCACHED: begin
                    res.kind   = SEG_DIRECT;
                    res.cached = 1'b0;
                    page[WIN_TOP-1:PAGE_BITS] = vaddr[WIN_TOP-1:PAGE_BITS];
                end
                SUB_MAP_A, SUB_MAP_B: res.kind = SEG_MAPPED;
                default:              res.kind = SEG_BAD;
            endcase
        end else if (phys_win) begin
            res.kind   = SEG_DIRECT;
            res.cached = (vaddr[CCA_LSB +: 2] != CCA_UNCACHED);
            page       = vaddr[PA_W-1:PAGE_BITS];
        end
    end
endmodule

// File: rtl/vseg_ctrl.sv
module vseg_ctrl
    import vseg_pkg::*;
#(
    parameter int PA_W      = 36,
    parameter int PAGE_BITS = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire,
    input  logic [63:0]             req_vaddr,
    input  logic                    req_store,
    input  logic                    req_probe,
    input  seg_res_t                dec,
    input  logic [PA_W-1:PAGE_BITS] dec_page,
    input  logic [63:0]             dec_tlb_va,
    output logic                    busy,
    output logic                    tlb_req_valid,
    output logic [63:0]             tlb_vaddr,
    input  logic                    tlb_ack,
    input  logic                    tlb_hit,
    input  logic [PA_W-PAGE_BITS-1:0] tlb_ppage,
    input  logic                    tlb_cached,
    output logic                    done,
    output logic                    ok,
    output logic [PA_W-1:0]         pa_page,
    output logic [PAGE_BITS-1:0]    pa_off,
    output logic                    cached,
    output logic                    exc_valid,
    output logic [4:0]              exc_cause,
    output logic [63:0]             badvaddr
);
    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    st_e         state;
    logic [63:0] hold_va;
    logic        hold_store;
    logic        hold_probe;

    assign busy          = (state == ST_WAIT);
    assign tlb_req_valid = (state == ST_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            hold_va    <= '0;
            hold_store <= 1'b0;
            hold_probe <= 1'b0;
            tlb_vaddr  <= '0;
            done       <= 1'b0;
            ok         <= 1'b0;
            pa_page    <= '0;
            pa_off     <= '0;
            cached     <= 1'b0;
            exc_valid  <= 1'b0;
            exc_cause  <= '0;
            badvaddr   <= '0;
        end else begin
            done      <= 1'b0;
            exc_valid <= 1'b0;
            if (state == ST_IDLE && fire) begin
                hold_va    <= req_vaddr;
                hold_store <= req_store;
                hold_probe <= req_probe;
                pa_off     <= req_vaddr[PAGE_BITS-1:0];
                unique case (dec.kind)
                    SEG_DIRECT: begin
                        done    <= 1'b1;
                        ok      <= 1'b1;
                        pa_page <= {dec_page, {PAGE_BITS{1'b0}}};
                        cached  <= dec.cached;
                    end
                    SEG_MAPPED: begin
                        state     <= ST_WAIT;
                        tlb_vaddr <= dec_tlb_va;
                    end
                    default: begin
                        done    <= 1'b1;
                        ok      <= 1'b0;
                        pa_page <= '0;
                        cached  <= 1'b0;
                        if (!req_probe) begin
                            exc_valid <= 1'b1;
                            exc_cause <= pick_cause(1'b0, req_store);
                            badvaddr  <= req_vaddr;
                        end
                    end
                endcase
            end else if (state == ST_WAIT && tlb_ack) begin
                state <= ST_IDLE;
                done  <= 1'b1;
                if (tlb_hit) begin
                    ok      <= 1'b1;
                    pa_page <= {tlb_ppage, {PAGE_BITS{1'b0}}};
                    cached  <= tlb_cached;
                end else begin
                    ok      <= 1'b0;
                    pa_page <= '0;
                    cached  <= 1'b0;
                    if (!hold_probe) begin
                        exc_valid <= 1'b1;
                        exc_cause <= pick_cause(1'b1, hold_store);
                        badvaddr  <= hold_va;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate
    import vseg_pkg::*;
#(
    parameter int PA_W      = 36,
    parameter int PAGE_BITS = 12,
    parameter int CCA_LSB   = 59
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      mode64_i,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [63:0]               req_vaddr,
    input  logic                      req_store,
    input  logic                      req_probe,
    output logic                      tlb_req_valid,
    output logic [63:0]               tlb_vaddr,
    input  logic                      tlb_ack,
    input  logic                      tlb_hit,
    input  logic [PA_W-PAGE_BITS-1:0] tlb_ppage,
    input  logic                      tlb_cached,
    output logic                      done,
    output logic                      ok,
    output logic [PA_W-1:0]           pa_page,
    output logic [PAGE_BITS-1:0]      pa_off,
    output logic                      cached,
    output logic                      exc_valid,
    output logic [4:0]                exc_cause,
    output logic [63:0]               badvaddr
);
    logic                    mode_q;
    logic                    busy;
    logic                    fire;
    seg_res_t                res32, res64, res_sel;
    logic [PA_W-1:PAGE_BITS] page32, page64, page_sel;
    logic [63:0]             tlb_va_sel;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= mode64_i;
    end

    assign req_ready = !busy;
    assign fire      = req_valid && !busy;

    vseg_decode32 #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_dec32 (
        .vaddr (req_vaddr[31:PAGE_BITS]),
        .res   (res32),
        .page  (page32)
    );

    vseg_decode64 #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .CCA_LSB(CCA_LSB)) u_dec64 (
        .vaddr (req_vaddr[63:PAGE_BITS]),
        .res   (res64),
        .page  (page64)
    );

    assign res_sel    = mode_q ? res64  : res32;
    assign page_sel   = mode_q ? page64 : page32;
    assign tlb_va_sel = mode_q ? req_vaddr : sext32(req_vaddr[31:0]);

    vseg_ctrl #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .fire          (fire),
        .req_vaddr     (req_vaddr),
        .req_store     (req_store),
        .req_probe     (req_probe),
        .dec           (res_sel),
        .dec_page      (page_sel),
        .dec_tlb_va    (tlb_va_sel),
        .busy          (busy),
        .tlb_req_valid (tlb_req_valid),
        .tlb_vaddr     (tlb_vaddr),
        .tlb_ack       (tlb_ack),
        .tlb_hit       (tlb_hit),
        .tlb_ppage     (tlb_ppage),
        .tlb_cached    (tlb_cached),
        .done          (done),
        .ok            (ok),
        .pa_page       (pa_page),
        .pa_off        (pa_off),
        .cached        (cached),
        .exc_valid     (exc_valid),
        .exc_cause     (exc_cause),
        .badvaddr      (badvaddr)
    );
endmodule

// File: rtl/vseg_xlate_chk.sv
module vseg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        mode_q,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_vaddr,
    input logic        req_probe,
    input logic        tlb_req_valid,
    input logic [63:0] tlb_vaddr,
    input logic        tlb_ack,
    input logic        done,
    input logic        ok,
    input logic        cached,
    input logic        exc_valid,
    input logic [4:0]  exc_cause,
    input logic [63:0] badvaddr
);
    logic probe_q;

    always_ff @(posedge clk) begin
        if (rst)                         probe_q <= 1'b0;
        else if (req_valid && req_ready) probe_q <= req_probe;
    end

    // R7 and R8: an exception only accompanies a failed completion
    a_r8_exc_on_fail: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (done && !ok));

    a_r7_cause_set: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (exc_cause >= 5'd2 && exc_cause <= 5'd5));

    a_r9_probe_quiet: assert property (@(posedge clk) disable iff (rst)
        (done && probe_q) |-> !exc_valid);

    a_r9_bad_only_on_exc: assert property (@(posedge clk) disable iff (rst)
        !$stable(badvaddr) |-> exc_valid);

    a_r3_tlb_hold: assert property (@(posedge clk) disable iff (rst)
        (tlb_req_valid && !tlb_ack) |=> (tlb_req_valid && $stable(tlb_vaddr)));

    a_r12_busy: assert property (@(posedge clk) disable iff (rst)
        tlb_req_valid |-> !req_ready);

    a_r10_ack_completes: assert property (@(posedge clk) disable iff (rst)
        (tlb_req_valid && tlb_ack) |=> (done && !tlb_req_valid));

    a_r2_low_cached: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !mode_q && req_vaddr[31:29] == 3'd4) |=> (done && ok && cached));
endmodule

bind vseg_xlate vseg_xlate_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_q        (mode_q),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_probe     (req_probe),
    .tlb_req_valid (tlb_req_valid),
    .tlb_vaddr     (tlb_vaddr),
    .tlb_ack       (tlb_ack),
    .done          (done),
    .ok            (ok),
    .cached        (cached),
    .exc_valid     (exc_valid),
    .exc_cause     (exc_cause),
    .badvaddr      (badvaddr)
);

// File: tb/vseg_xlate_tb.sv
module vseg_xlate_tb;
    localparam int PA_W = 36;
    localparam int PG   = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode64_i = 1'b0;
    logic req_valid = 1'b0, req_store = 1'b0, req_probe = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic req_ready, tlb_req_valid;
    logic [63:0] tlb_vaddr;
    logic tlb_ack = 1'b0, tlb_hit = 1'b0, tlb_cached = 1'b0;
    logic [PA_W-PG-1:0] tlb_ppage = '0;
    logic done, ok, cached, exc_valid;
    logic [PA_W-1:0] pa_page;
    logic [PG-1:0] pa_off;
    logic [4:0] exc_cause;
    logic [63:0] badvaddr;

    int n_chk = 0, n_fail = 0;
    logic [63:0] exp_bad = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vseg_xlate u_dut (.*);

    task automatic check(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // kind: 0 unmapped, 1 mapped, 2 address error
    function automatic void ref_decode(input bit m64, input logic [63:0] va,
                                       output int kind, output logic [PA_W-1:0] pg, output bit cc);
        logic [63:0] d;
        kind = 2; pg = '0; cc = 0;
        if (!m64) begin
            case (va[31:29])
                3'd4: begin kind = 0; cc = 1; d = {32'h0, va[31:0]} - 64'h80000000; pg = d[PA_W-1:0] & ~36'hFFF; end
                3'd5: begin kind = 0; cc = 0; d = {32'h0, va[31:0]} - 64'hA0000000; pg = d[PA_W-1:0] & ~36'hFFF; end
                default: kind = 1;
            endcase
        end else if (va[63:40] == 24'h0 || va[63:40] == 24'h400000 || va[63:40] == 24'hC00000) begin
            kind = 1;
        end else if (va[63:40] == 24'hFFFFFF) begin
            if (va[39:29] == 11'h7FC) begin kind = 0; cc = 1; d = va - 64'hFFFFFFFF80000000; pg = d[PA_W-1:0] & ~36'hFFF; end
            else if (va[39:29] == 11'h7FD) begin kind = 0; cc = 0; d = va - 64'hFFFFFFFFA0000000; pg = d[PA_W-1:0] & ~36'hFFF; end
            else if (va[39:29] >= 11'h7FE) kind = 1;
        end else begin
            for (int k = 0; k < 8; k++)
                if (va[63:40] == 24'h800000 + 24'(k) * 24'h080000) begin
                    kind = 0;
                    cc = (((va >> 59) & 64'h3) != 64'h2);
                    pg = va[PA_W-1:0] & ~36'hFFF;
                end
        end
    endfunction

    task automatic do_req(input bit m64, input logic [63:0] va, input bit st, input bit pr,
                          input bit hit, input logic [PA_W-PG-1:0] pp, input bit tc,
                          input int dly, input bit mode_late);
        int kind; logic [PA_W-1:0] pg; bit cc;
        logic [63:0] xva;
        string tg;
        bit exp_ok, exp_exc; logic [4:0] exp_cause; logic [PA_W-1:0] exp_pg; bit exp_cc;
        ref_decode(m64, va, kind, pg, cc);
        if (!mode_late) begin
            mode64_i = m64;
            @(negedge clk);
        end
        tg = (kind == 2) ? "R7" : (kind == 1) ? (m64 ? "R4" : "R3") :
             (!m64 ? "R2" : (va[63:40] == 24'hFFFFFF) ? "R5" : "R6");
        if (mode_late) tg = "R1";
        req_valid = 1; req_vaddr = va; req_store = st; req_probe = pr;
        @(negedge clk);
        req_valid = 0;
        exp_ok = 1; exp_exc = 0; exp_cause = 0; exp_pg = pg; exp_cc = cc;
        if (kind == 1) begin
            xva = m64 ? va : {{32{va[31]}}, va[31:0]};
            check(tlb_req_valid === 1'b1, {tg, " tlb request raised"}, 64'(tlb_req_valid), 64'd1);
            check(tlb_vaddr === xva, {tg, " tlb address"}, tlb_vaddr, xva);
            check(req_ready === 1'b0, "R12 not ready while waiting", 64'(req_ready), 64'd0);
            for (int i = 0; i < dly; i++) begin
                req_valid = 1; req_vaddr = 64'hFFFF_FFFF_8000_0000 ^ 64'($urandom); req_store = ~st; req_probe = ~pr;
                @(negedge clk);
                check(tlb_req_valid === 1'b1 && done === 1'b0, "R12 request ignored during wait", 64'(done), 64'd0);
            end
            req_valid = 0;
            tlb_ack = 1; tlb_hit = hit; tlb_ppage = pp; tlb_cached = tc;
            @(negedge clk);
            tlb_ack = 0;
            tg = hit ? "R10" : (pr ? "R9" : "R8");
            if (hit) begin exp_pg = {pp, 12'h000}; exp_cc = tc; end
            else begin exp_ok = 0; exp_exc = !pr; exp_cause = st ? 5'd3 : 5'd2; end
        end else if (kind == 2) begin
            exp_ok = 0; exp_exc = !pr; exp_cause = st ? 5'd5 : 5'd4;
            if (pr) tg = "R9";
        end
        if (exp_exc) exp_bad = va;
        check(done === 1'b1, {tg, " done"}, 64'(done), 64'd1);
        check(ok === exp_ok, {tg, " ok"}, 64'(ok), 64'(exp_ok));
        check(exc_valid === exp_exc, {tg, " exc_valid"}, 64'(exc_valid), 64'(exp_exc));
        check(badvaddr === exp_bad, {tg, " badvaddr"}, badvaddr, exp_bad);
        if (exp_exc) check(exc_cause === exp_cause, {tg, " cause"}, 64'(exc_cause), 64'(exp_cause));
        if (exp_ok) begin
            check(pa_page === exp_pg, {tg, " pa_page"}, 64'(pa_page), 64'(exp_pg));
            check(cached === exp_cc, {tg, " cached"}, 64'(cached), 64'(exp_cc));
            check(pa_off === va[11:0], {tg, " pa_off"}, 64'(pa_off), 64'(va[11:0]));
        end
        @(negedge clk);
        check(done === 1'b0 && req_ready === 1'b1, {tg, " back to idle"}, 64'({done, req_ready}), 64'd1);
    endtask

    function automatic logic [63:0] gen_va(input int cls);
        logic [63:0] v = {$urandom, $urandom};
        logic [10:0] subs [4] = '{11'h7FC, 11'h7FD, 11'h7FE, 11'h7FF};
        case (cls)
            1: begin
                case ($urandom % 3)
                    0: v[63:40] = 24'h000000;
                    1: v[63:40] = 24'h400000;
                    default: v[63:40] = 24'hC00000;
                endcase
            end
            2: begin
                v[63:40] = 24'hFFFFFF;
                if ($urandom % 5 != 0) v[39:29] = subs[$urandom % 4];
            end
            3: begin
                v[63:62] = 2'b10; v[61:59] = 3'($urandom); v[58:40] = '0;
            end
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(req_ready === 1'b1 && done === 1'b0 && exc_valid === 1'b0 && tlb_req_valid === 1'b0,
              "R11 reset outputs", 64'({req_ready, done, exc_valid, tlb_req_valid}), 64'b1000);
        check(badvaddr === 64'h0, "R11 badvaddr reset", badvaddr, 64'h0);
        // R11: mode is 32-bit after reset; high address bits ignored
        mode64_i = 0;
        do_req(0, 64'h1234_5678_8000_1ABC, 0, 0, 0, '0, 0, 0, 1);
        // R2 directed kseg windows
        do_req(0, 64'h0000_0000_9FFF_FFFF, 0, 0, 0, '0, 0, 0, 0);
        do_req(0, 64'h0000_0000_A000_0000, 1, 0, 0, '0, 0, 0, 0);
        // R1: mode changes together with the request; old mode (32-bit) applies
        mode64_i = 0; @(negedge clk);
        mode64_i = 1;
        do_req(0, 64'h0000_0000_8000_1000, 0, 0, 0, '0, 0, 0, 1);
        // R5, R6, R7 directed
        do_req(1, 64'hFFFF_FFFF_8000_0123, 0, 0, 0, '0, 0, 0, 0);
        do_req(1, 64'hFFFF_FFFF_BFFF_F456, 0, 0, 0, '0, 0, 0, 0);
        do_req(1, 64'h9000_000F_FFFF_F789, 0, 0, 0, '0, 0, 0, 0);
        do_req(1, 64'hFFFF_FF00_0000_0000, 1, 0, 0, '0, 0, 0, 0);
        do_req(1, 64'h7000_0000_0000_0000, 0, 0, 0, '0, 0, 0, 0);
        // R9: probe failures leave badvaddr alone
        do_req(1, 64'h1000_0000_0000_0000, 0, 1, 0, '0, 0, 0, 0);
        do_req(1, 64'h4000_0000_0000_0040, 1, 1, 0, 24'h0, 0, 2, 0);
        // R8 and R10 on 32-bit mapped segments
        do_req(0, 64'h0000_0000_C000_0008, 1, 0, 0, 24'h0, 0, 1, 0);
        do_req(0, 64'h0000_0000_0040_0FFC, 0, 0, 1, 24'hABCDE, 1, 3, 0);
        for (int n = 0; n < 400; n++) begin
            int cls = $urandom % 5;
            do_req(1'($urandom), gen_va(cls), 1'($urandom), ($urandom % 4) == 0,
                   1'($urandom), 24'($urandom), 1'($urandom), $urandom % 4, 0);
        end
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end
endmodule